// File: doc/BRIEF.md
# Monitor Power-Mode Controller

This block owns the run, low-power-select and lock control bits of a hardware monitor and turns them into one of three operating modes: monitoring, sleep or shutdown. From the mode it drives enables for the oscillator, the bias generator, the converter and the monitoring cycle. In either low-power mode it also asserts a request that forces every PWM output to full duty.

The block sits on a generic register bus. Three registers are local to it: a run-control register at 0x40, a power-select register at 0x7C and a configuration register at 0x7F. Accesses to any other address are passed on to the rest of the monitor's register file.

In shutdown the block filters the bus. Only the low three bits of the power-select register and all of the configuration register can be written, and every read returns zero. A register write that changes the mode takes effect on the clock edge that performs the write, so the new mode is visible in the following cycle.

Top module: `hm_pwrmode_ctl`

## Requirements
- R1: After reset the run-control, power-select and configuration registers all read 0x00, the lock is clear, and the block is in sleep mode.
- R2: `mode_o` encodes monitoring as 0, sleep as 1 and shutdown as 2. The run bit (bit 0 of 0x40) set gives monitoring whatever the select bit is. Run clear with the select bit (bit 0 of 0x7C) clear gives sleep. Run clear with the select bit set gives shutdown. A write that changes these bits changes `mode_o` in the cycle after the write.
- R3: In monitoring all four enables (`osc_en`, `bias_en`, `adc_en`, `cycle_en`) are high. In sleep `osc_en` and `bias_en` are high while `adc_en` and `cycle_en` are low. In shutdown all four are low.
- R4: `pwm_full` is high in sleep and in shutdown, and low in monitoring.
- R5: Writing 1 to bit 1 of 0x40 sets the lock. Only reset clears it: a later write of 0 to that bit leaves it set.
- R6: While the lock is set, writes cannot change the run bit or the select bit. Bits 7:2 of 0x40 and bits 7:1 of 0x7C stay writable.
- R7: Outside shutdown, a read of 0x40, 0x7C or 0x7F returns the stored value. An access to any other address is forwarded: `fwd_rd` follows `bus_rd`, `fwd_wr` follows `bus_wr`, and `bus_rdata` returns `ext_rdata`.
- R8: In shutdown every read returns 0x00, `fwd_rd` and `fwd_wr` stay low, and writes to 0x40 are ignored.
- R9: In shutdown a write to 0x7F updates all eight bits. A write to 0x7C updates only bits 2:0 and leaves bits 7:3 unchanged.
- R10: Entering or leaving a low-power mode does not change any stored register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| ext_rdata | input | 8 | Read data from the rest of the register file |
| fwd_wr | output | 1 | Write forwarded to the rest of the register file |
| fwd_rd | output | 1 | Read forwarded to the rest of the register file |
| mode_o | output | 2 | Current mode: 0 monitoring, 1 sleep, 2 shutdown |
| osc_en | output | 1 | Oscillator enable |
| bias_en | output | 1 | Bias generator enable |
| adc_en | output | 1 | Converter enable |
| cycle_en | output | 1 | Monitoring-cycle enable |
| pwm_full | output | 1 | Force all PWM outputs to 100% duty |

## Verification
A wrong run, select or lock bit shows up in the cycle after the offending write, as a wrong `mode_o` together with wrong enables and a wrong `pwm_full` level. A corrupted stored field is invisible until the register is read back outside shutdown, so the bench reads every register after each mode transition. A filter that mistakes the current mode shows up on the same cycle as the access: forward strobes or non-zero read data appear during shutdown, or they go missing in sleep.

// File: rtl/hm_pwr_pkg.sv
package hm_pwr_pkg;

  localparam int PM_AW = 8;
  localparam int PM_DW = 8;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_SLEEP = 2'd1,
    PM_OFF   = 2'd2
  } pm_mode_e;

  typedef struct packed {
    logic osc;
    logic bias;
    logic adc;
    logic cyc;
    logic pwm_full;
  } pm_ctrl_t;

  // run bit dominates; otherwise the select bit picks the depth
  function automatic pm_mode_e pm_decode(input logic run, input logic deep);
    if (run)       return PM_RUN;
    else if (deep) return PM_OFF;
    else           return PM_SLEEP;
  endfunction

  function automatic pm_ctrl_t pm_ctrl_of(input pm_mode_e m);
    pm_ctrl_t c;
    c.osc      = (m != PM_OFF);
    c.bias     = (m != PM_OFF);
    c.adc      = (m == PM_RUN);
    c.cyc      = (m == PM_RUN);
    c.pwm_full = (m != PM_RUN);
    return c;
  endfunction

  // masked merge used for partial-bit writes
  function automatic logic [PM_DW-1:0] pm_merge(input logic [PM_DW-1:0] old_v,
                                                input logic [PM_DW-1:0] new_v,
                                                input logic [PM_DW-1:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

endpackage

// File: rtl/hm_pm_access.sv
module hm_pm_access
  import hm_pwr_pkg::*;
#(
  parameter int AW = PM_AW,
  parameter int DW = PM_DW,
  parameter logic [AW-1:0] CTL_ADDR = 8'h40,
  parameter logic [AW-1:0] SEL_ADDR = 8'h7C,
  parameter logic [AW-1:0] CFG_ADDR = 8'h7F,
  parameter logic [DW-1:0] OFF_SEL_MASK = 8'h07
) (
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic          in_off,
  output logic          hit_ctl,
  output logic          hit_sel,
  output logic          hit_cfg,
  output logic          we_ctl,
  output logic          we_sel,
  output logic          we_cfg,
  output logic [DW-1:0] sel_wmask,
  output logic          fwd_wr,
  output logic          fwd_rd,
  output logic          rd_blank
);

  logic hit_local;

  always_comb begin
    hit_ctl   = (bus_addr == CTL_ADDR);
    hit_sel   = (bus_addr == SEL_ADDR);
    hit_cfg   = (bus_addr == CFG_ADDR);
    hit_local = hit_ctl | hit_sel | hit_cfg;

    // run-control register is sealed during shutdown
    we_ctl    = bus_wr & hit_ctl & ~in_off;
    we_sel    = bus_wr & hit_sel;
    we_cfg    = bus_wr & hit_cfg;
    sel_wmask = in_off ? OFF_SEL_MASK : {DW{1'b1}};

    fwd_wr    = bus_wr & ~hit_local & ~in_off;
    fwd_rd    = bus_rd & ~hit_local & ~in_off;
    rd_blank  = in_off;
  end

endmodule

// File: rtl/hm_pm_regs.sv
module hm_pm_regs
  import hm_pwr_pkg::*;
#(
  parameter int DW       = PM_DW,
  parameter int RUN_BIT  = 0,
  parameter int LOCK_BIT = 1,
  parameter int DEEP_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_ctl,
  input  logic          we_sel,
  input  logic          we_cfg,
  input  logic [DW-1:0] sel_wmask,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctl_q,
  output logic [DW-1:0] sel_q,
  output logic [DW-1:0] cfg_q,
  output logic          run,
  output logic          deep,
  output logic          locked
);

  logic [DW-1:0] ctl_d, sel_d;

  assign run    = ctl_q[RUN_BIT];
  assign locked = ctl_q[LOCK_BIT];
  assign deep   = sel_q[DEEP_BIT];

  always_comb begin
    ctl_d = ctl_q;
    if (we_ctl) begin
      ctl_d           = wdata;
      ctl_d[LOCK_BIT] = ctl_q[LOCK_BIT] | wdata[LOCK_BIT];
      if (locked) ctl_d[RUN_BIT] = ctl_q[RUN_BIT];
    end
  end

  always_comb begin
    sel_d = sel_q;
    if (we_sel) begin
      sel_d = pm_merge(sel_q, wdata, sel_wmask);
      if (locked) sel_d[DEEP_BIT] = sel_q[DEEP_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      sel_q <= '0;
      cfg_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      sel_q <= sel_d;
      if (we_cfg) cfg_q <= wdata;
    end
  end

endmodule

// File: rtl/hm_pm_decode.sv
module hm_pm_decode
  import hm_pwr_pkg::*;
(
  input  logic     run,
  input  logic     deep,
  output pm_mode_e mode,
  output pm_ctrl_t ctrl
);

  always_comb begin
    mode = pm_decode(run, deep);
    ctrl = pm_ctrl_of(mode);
  end

endmodule

// File: rtl/hm_pwrmode_ctl.sv
module hm_pwrmode_ctl
  import hm_pwr_pkg::*;
#(
  parameter int AW = PM_AW,
  parameter int DW = PM_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] ext_rdata,
  output logic          fwd_wr,
  output logic          fwd_rd,
  output logic [1:0]    mode_o,
  output logic          osc_en,
  output logic          bias_en,
  output logic          adc_en,
  output logic          cycle_en,
  output logic          pwm_full
);

  logic          hit_ctl, hit_sel, hit_cfg;
  logic          we_ctl, we_sel, we_cfg, rd_blank;
  logic [DW-1:0] sel_wmask;
  logic [DW-1:0] ctl_q, sel_q, cfg_q;
  logic          run, deep, locked;
  logic          in_off;
  pm_mode_e      mode;
  pm_ctrl_t      ctrl;

  assign in_off = (mode == PM_OFF);

  hm_pm_access #(.AW(AW), .DW(DW)) u_access (
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .in_off    (in_off),
    .hit_ctl   (hit_ctl),
    .hit_sel   (hit_sel),
    .hit_cfg   (hit_cfg),
    .we_ctl    (we_ctl),
    .we_sel    (we_sel),
    .we_cfg    (we_cfg),
    .sel_wmask (sel_wmask),
    .fwd_wr    (fwd_wr),
    .fwd_rd    (fwd_rd),
    .rd_blank  (rd_blank)
  );

  hm_pm_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_ctl    (we_ctl),
    .we_sel    (we_sel),
    .we_cfg    (we_cfg),
    .sel_wmask (sel_wmask),
    .wdata     (bus_wdata),
    .ctl_q     (ctl_q),
    .sel_q     (sel_q),
    .cfg_q     (cfg_q),
    .run       (run),
    .deep      (deep),
    .locked    (locked)
  );

  hm_pm_decode u_decode (
    .run  (run),
    .deep (deep),
    .mode (mode),
    .ctrl (ctrl)
  );

  always_comb begin
    if (rd_blank)     bus_rdata = '0;
    else if (hit_ctl) bus_rdata = ctl_q;
    else if (hit_sel) bus_rdata = sel_q;
    else if (hit_cfg) bus_rdata = cfg_q;
    else              bus_rdata = ext_rdata;
  end

  assign mode_o   = mode;
  assign osc_en   = ctrl.osc;
  assign bias_en  = ctrl.bias;
  assign adc_en   = ctrl.adc;
  assign cycle_en = ctrl.cyc;
  assign pwm_full = ctrl.pwm_full;

endmodule

// File: rtl/hm_pwrmode_ctl_chk.sv
module hm_pwrmode_ctl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode_o,
  input logic          osc_en,
  input logic          bias_en,
  input logic          adc_en,
  input logic          cycle_en,
  input logic          pwm_full,
  input logic          fwd_wr,
  input logic          fwd_rd,
  input logic [DW-1:0] bus_rdata,
  input logic [DW-1:0] ctl_q,
  input logic          run,
  input logic          locked,
  input logic          deep
);

  AST_RUN_MEANS_MON: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (mode_o == 2'd0)); // R2

  AST_DEEP_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && deep) |-> (mode_o == 2'd2)); // R2

  AST_OFF_ALL_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2) |-> (!osc_en && !bias_en && !adc_en && !cycle_en)); // R3

  AST_MON_ALL_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0) |-> (osc_en && bias_en && adc_en && cycle_en)); // R3

  AST_LOWPWR_PWM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'd0) |-> pwm_full); // R4

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked); // R5

  AST_LOCK_FREEZES_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(run) && $stable(deep))); // R6

  AST_OFF_BUS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2) |-> (!fwd_wr && !fwd_rd && bus_rdata == '0)); // R8

  AST_OFF_CTL_SEALED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2) |=> $stable(ctl_q)); // R8

endmodule

bind hm_pwrmode_ctl hm_pwrmode_ctl_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_o    (mode_o),
  .osc_en    (osc_en),
  .bias_en   (bias_en),
  .adc_en    (adc_en),
  .cycle_en  (cycle_en),
  .pwm_full  (pwm_full),
  .fwd_wr    (fwd_wr),
  .fwd_rd    (fwd_rd),
  .bus_rdata (bus_rdata),
  .ctl_q     (ctl_q),
  .run       (run),
  .locked    (locked),
  .deep      (deep)
);

// File: tb/hm_pwrmode_ctl_tb.sv
`timescale 1ns/1ps
module hm_pwrmode_ctl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] ext_rdata = 8'hA5;
  logic [7:0] bus_rdata;
  logic       fwd_wr, fwd_rd;
  logic [1:0] mode_o;
  logic       osc_en, bias_en, adc_en, cycle_en, pwm_full;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hm_pwrmode_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_rdata(ext_rdata), .fwd_wr(fwd_wr), .fwd_rd(fwd_rd),
    .mode_o(mode_o), .osc_en(osc_en), .bias_en(bias_en), .adc_en(adc_en),
    .cycle_en(cycle_en), .pwm_full(pwm_full)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v, output logic f);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1;
    v = bus_rdata; f = fwd_rd;
    bus_rd = 1'b0;
  endtask

  // expected enables per mode, restated from R3/R4
  task automatic chk_mode(input string req, input int m);
    chk(req, mode_o, m);
    chk({req, " osc"},  osc_en,   (m != 2));
    chk({req, " bias"}, bias_en,  (m != 2));
    chk({req, " adc"},  adc_en,   (m == 0));
    chk({req, " cyc"},  cycle_en, (m == 0));
    chk({req, " pwm"},  pwm_full, (m != 0));
  endtask

  task automatic t_reset();
    logic [7:0] v; logic f;
    rd(8'h40, v, f); chk("R1 ctl", v, 8'h00);
    rd(8'h7C, v, f); chk("R1 sel", v, 8'h00);
    rd(8'h7F, v, f); chk("R1 cfg", v, 8'h00);
    chk_mode("R1 R3 R4 reset sleep", 1);
  endtask

  task automatic t_modes();
    wr(8'h40, 8'h01);
    chk_mode("R2 R3 R4 run", 0);
    wr(8'h7C, 8'h01);
    chk("R2 select ignored while running", mode_o, 0);
    wr(8'h7F, 8'h3C);
    wr(8'h40, 8'h00);
    chk_mode("R2 R3 R4 shutdown", 2);
  endtask

  task automatic t_shutdown();
    logic [7:0] v; logic f;
    rd(8'h7F, v, f); chk("R8 cfg read blank", v, 8'h00);
    rd(8'h20, v, f); chk("R8 ext read blank", v, 8'h00);
    chk("R8 no fwd_rd", f, 0);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h21; bus_wdata = 8'h11;
    #1; chk("R8 no fwd_wr", fwd_wr, 0);
    @(negedge clk); bus_wr = 1'b0;
    wr(8'h40, 8'h01);
    chk("R8 ctl write ignored", mode_o, 2);
    wr(8'h7F, 8'h5A);
    wr(8'h7C, 8'hFE);
    chk_mode("R9 sel low bits reach sleep", 1);
    rd(8'h7F, v, f); chk("R9 cfg written in shutdown", v, 8'h5A);
    rd(8'h7C, v, f); chk("R9 sel upper bits held", v, 8'h06);
    rd(8'h40, v, f); chk("R10 ctl retained", v, 8'h00);
  endtask

  task automatic t_fwd();
    logic [7:0] v; logic f;
    rd(8'h20, v, f);
    chk("R7 ext rdata", v, 8'hA5);
    chk("R7 fwd_rd", f, 1);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h21; bus_wdata = 8'h11;
    #1; chk("R7 fwd_wr", fwd_wr, 1);
    @(negedge clk); bus_wr = 1'b0;
    rd(8'h40, v, f); chk("R7 local no fwd", f, 0);
  endtask

  task automatic t_lock();
    logic [7:0] v; logic f;
    wr(8'h40, 8'hF3);
    rd(8'h40, v, f); chk("R5 lock set", v, 8'hF3);
    chk("R5 run", mode_o, 0);
    wr(8'h40, 8'h00);
    rd(8'h40, v, f); chk("R5 R6 lock and run held, upper written", v, 8'h03);
    chk("R6 still running", mode_o, 0);
    wr(8'h7C, 8'hA9);
    rd(8'h7C, v, f); chk("R6 select held, upper written", v, 8'hA8);
    rd(8'h7F, v, f); chk("R10 cfg retained", v, 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_modes();
    t_shutdown();
    t_fwd();
    t_lock();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule